// File: doc/BRIEF.md
# Port Status Blink-Code LED Driver

This block turns the state of one power-sourcing port into a pattern on a single open-drain status LED. While the port delivers power, the LED stays lit. While the port is idle, the LED is dark. After certain faults the LED shows a repeating blink code, and the number of flashes in each burst tells an observer which fault occurred. An overcurrent trip gives two flashes per burst. A rejected detection signature gives five.

Every flash uses the same lit time and the same dark time. A longer dark gap separates one burst from the next. All of these durations are counted in periods of an external timebase strobe, so the same logic runs from any system clock. When the optional low-power mode is on, the lit state is chopped by a free-running carrier whose on-time is one sixteenth of its period. The carrier period is a parameter, counted in clock cycles.

A fault event is held until the current burst has finished, and is only shown from the next burst onward. Power applied to the port always lights the LED at once, and it erases any stored code.

Top module: `poe_led_coder`

## Requirements
- R1: After reset the LED output is 0 (dark), and no blink code runs until a fault event arrives.
- R2: While `port_pwr` is 1 and `pwm_en` is 0, `led_sink` is 1 in every cycle.
- R3: Raising `port_pwr` lights the LED in that same cycle, even in the middle of a burst, and the burst sequencer is held idle while power stays on.
- R4: An overcurrent event gives repeating bursts once the port is unpowered. Each burst is OC_FLASHES (2) flashes, each ON_TICKS lit and OFF_TICKS dark, followed by GAP_TICKS of extra dark. The first lit cycle comes one cycle after the pending event is seen with power off.
- R5: A detection event gives the same kind of repeating burst, with DET_FLASHES (5) flashes per burst.
- R6: A fault event that arrives while a code is running does not change the burst in progress. The new code starts with the first burst after the current gap ends.
- R7: A rising edge of `port_pwr` clears both the running code and any pending code. When power is later removed, the LED stays dark.
- R8: While `pwm_en` is 1, the LED may only be lit during the first PWM_DIV/16 clock cycles of each PWM_DIV-cycle carrier period. The carrier is counted from the first cycle after reset is released.
- R9: Blink timing moves forward only on cycles where `tick` is 1. Any cycle without a tick stretches the current lit, dark or gap phase by one cycle.
- R10: If an overcurrent event and a detection event arrive in the same cycle, the detection code is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timebase strobe that advances the blink timers |
| port_pwr | input | 1 | Port is powering a valid device |
| oc_fault | input | 1 | One-cycle overcurrent fault event |
| det_fault | input | 1 | One-cycle invalid-signature detection event |
| pwm_en | input | 1 | Enables chopping of the lit state |
| led_sink | output | 1 | 1 turns on the open-drain LED pull-down |

## Verification
The bench builds the block with ON_TICKS=3, OFF_TICKS=4, GAP_TICKS=10 and PWM_DIV=32, and with the tick strobe active in most cycles. With these values, complete two-flash and five-flash bursts, the code change at a gap boundary and whole carrier periods all fit into a few hundred cycles. Because tick is high in most cycles, each expected pattern can be counted cycle by cycle. Dropping tick for a stretch then shows the phase stretching. With a 32-cycle carrier, the two-cycle on-window can be checked against the cycle count since reset.

// File: rtl/poe_led_coder.sv
module poe_led_coder #(
  parameter int ON_TICKS    = 74,
  parameter int OFF_TICKS   = 223,
  parameter int GAP_TICKS   = 1400,
  parameter int OC_FLASHES  = 2,
  parameter int DET_FLASHES = 5,
  parameter int PWM_DIV     = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic port_pwr,
  input  logic oc_fault,
  input  logic det_fault,
  input  logic pwm_en,
  output logic led_sink
);
  localparam int MAXT   = (GAP_TICKS > ON_TICKS) ? ((GAP_TICKS > OFF_TICKS) ? GAP_TICKS : OFF_TICKS)
                                                 : ((ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS);
  localparam int MAXF   = (DET_FLASHES > OC_FLASHES) ? DET_FLASHES : OC_FLASHES;
  localparam int CW     = $clog2(MAXT + 1);
  localparam int FW     = $clog2(MAXF + 1);
  localparam int PW     = $clog2(PWM_DIV);
  localparam int PWM_ON = PWM_DIV / 16;

  localparam logic [1:0] C_NONE = 2'd0, C_OC = 2'd1, C_DET = 2'd2;
  localparam logic [1:0] P_IDLE = 2'd0, P_ON = 2'd1, P_OFF = 2'd2, P_GAP = 2'd3;

  logic [1:0]    phase, code, pend;
  logic [CW-1:0] cnt;
  logic [FW-1:0] fl;
  logic [PW-1:0] pcnt;
  logic          pwr_q;

  wire           pwr_rise = port_pwr & ~pwr_q;
  wire           evt      = det_fault | oc_fault;
  wire [1:0]     pend_nx  = det_fault ? C_DET : (oc_fault ? C_OC : pend);
  wire [FW-1:0]  fl_last  = (code == C_DET) ? FW'(DET_FLASHES - 1) : FW'(OC_FLASHES - 1);
  wire [CW-1:0]  span     = (phase == P_ON)  ? CW'(ON_TICKS - 1)  :
                            (phase == P_OFF) ? CW'(OFF_TICKS - 1) : CW'(GAP_TICKS - 1);
  wire           span_end = tick && (cnt == span);

  assign led_sink = (port_pwr | (phase == P_ON)) & (~pwm_en | (pcnt < PW'(PWM_ON)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_IDLE;
      code  <= C_NONE;
      pend  <= C_NONE;
      cnt   <= '0;
      fl    <= '0;
      pcnt  <= '0;
      pwr_q <= 1'b0;
    end else begin
      pwr_q <= port_pwr;
      pcnt  <= (pcnt == PW'(PWM_DIV - 1)) ? '0 : pcnt + 1'b1;
      pend  <= pend_nx;
      if (pwr_rise) begin
        code  <= C_NONE;
        pend  <= C_NONE;
        phase <= P_IDLE;
        cnt   <= '0;
        fl    <= '0;
      end else if (port_pwr) begin
        phase <= P_IDLE;
        cnt   <= '0;
        fl    <= '0;
      end else begin
        case (phase)
          P_IDLE: if (pend != C_NONE) begin
            code  <= pend;
            pend  <= evt ? pend_nx : C_NONE;
            phase <= P_ON;
            cnt   <= '0;
            fl    <= '0;
          end
          P_ON: begin
            if (span_end) begin
              phase <= P_OFF;
              cnt   <= '0;
            end else if (tick) cnt <= cnt + 1'b1;
          end
          P_OFF: begin
            if (span_end) begin
              cnt <= '0;
              if (fl == fl_last) phase <= P_GAP;
              else begin
                fl    <= fl + 1'b1;
                phase <= P_ON;
              end
            end else if (tick) cnt <= cnt + 1'b1;
          end
          default: begin
            if (span_end) begin
              cnt   <= '0;
              fl    <= '0;
              phase <= P_ON;
              if (pend != C_NONE) begin
                code <= pend;
                pend <= evt ? pend_nx : C_NONE;
              end
            end else if (tick) cnt <= cnt + 1'b1;
          end
        endcase
      end
    end
  end
endmodule

module poe_led_coder_chk #(
  parameter int PWM_DIV = 2000
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tick,
  input logic                       port_pwr,
  input logic                       pwm_en,
  input logic                       led_sink,
  input logic [1:0]                 phase,
  input logic [1:0]                 code,
  input logic [1:0]                 pend,
  input logic [$clog2(PWM_DIV)-1:0] pcnt
);
  localparam int PW = $clog2(PWM_DIV);

  // R1
  reset_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) && !port_pwr |-> !led_sink);

  // R2
  powered_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_pwr && !pwm_en |-> led_sink);

  // R3
  power_holds_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_pwr |=> phase == 2'd0);

  // R6
  code_steady_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_pwr && (phase == 2'd1 || phase == 2'd2) |=> $stable(code));

  // R7
  power_clears_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_pwr) |=> code == 2'd0 && pend == 2'd0);

  // R8
  pwm_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en && led_sink |-> pcnt < PW'(PWM_DIV / 16));

  // R9
  no_tick_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !port_pwr && phase != 2'd0 |=> $stable(phase));
endmodule

bind poe_led_coder poe_led_coder_chk #(.PWM_DIV(PWM_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .port_pwr(port_pwr), .pwm_en(pwm_en),
  .led_sink(led_sink), .phase(phase), .code(code), .pend(pend), .pcnt(pcnt)
);

// File: tb/sim_poe_led_coder.sv
`timescale 1ns/1ps
module sim_poe_led_coder;
  localparam int ON = 3, OFF = 4, GAP = 10, DIV = 32;

  logic clk = 0, rst_n = 0, tick = 0, port_pwr = 0, oc_fault = 0, det_fault = 0, pwm_en = 0;
  logic led_sink;

  poe_led_coder #(.ON_TICKS(ON), .OFF_TICKS(OFF), .GAP_TICKS(GAP),
                  .OC_FLASHES(2), .DET_FLASHES(5), .PWM_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .port_pwr(port_pwr), .oc_fault(oc_fault),
    .det_fault(det_fault), .pwm_en(pwm_en), .led_sink(led_sink));

  always #2.5 clk = ~clk;

  typedef struct { logic e; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0, cyc = 0;
  logic d_pwr = 0, d_tick = 1, d_pwm = 0, d_oc = 0, d_det = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (led_sink !== it.e) begin
        errors++;
        $display("FAIL %s cycle %0d: led_sink=%0b expected %0b", it.tag, cyc, led_sink, it.e);
      end
    end
  end

  task automatic step(logic e, string tag);
    @(posedge clk); #1;
    cyc++;
    port_pwr = d_pwr; tick = d_tick; pwm_en = d_pwm; oc_fault = d_oc; det_fault = d_det;
    d_oc = 0; d_det = 0;
    q.push_back('{e, tag});
  endtask

  task automatic run(int n, logic e, string tag);
    for (int i = 0; i < n; i++) step(e, tag);
  endtask

  task automatic burst(int n, string tag);
    for (int i = 0; i < n; i++) begin
      run(ON, 1'b1, tag);
      run(OFF, 1'b0, tag);
    end
    run(GAP, 1'b0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1; tick = 1; cyc = 0;
    q.push_back('{1'b0, "R1"});
    run(5, 1'b0, "R1");
    // R2 steady on
    d_pwr = 1; run(6, 1'b1, "R2");
    // R4 overcurrent while powered, code after power drops
    d_oc = 1; step(1'b1, "R4");
    run(3, 1'b1, "R4");
    d_pwr = 0; step(1'b0, "R4");
    burst(2, "R4"); burst(2, "R4");
    // R6 detection event mid-burst; R10 both at once picks detection
    d_det = 1; d_oc = 1; step(1'b1, "R6");
    run(2, 1'b1, "R6"); run(OFF, 1'b0, "R6");
    run(ON, 1'b1, "R6"); run(OFF, 1'b0, "R6"); run(GAP, 1'b0, "R6");
    burst(5, "R5"); burst(5, "R10");
    // R3 power overrides blinking mid-burst
    run(1, 1'b1, "R3");
    d_pwr = 1; run(8, 1'b1, "R3");
    // R7 code cleared by power-up
    d_pwr = 0; run(40, 1'b0, "R7");
    // R9 tick stall stretches the lit phase
    d_pwr = 1; run(3, 1'b1, "R9");
    d_det = 1; step(1'b1, "R9");
    run(2, 1'b1, "R9");
    d_pwr = 0; step(1'b0, "R9");
    step(1'b1, "R9");
    d_tick = 0; run(5, 1'b1, "R9");
    d_tick = 1; run(ON - 1, 1'b1, "R9"); run(OFF, 1'b0, "R9");
    for (int i = 0; i < 4; i++) begin
      run(ON, 1'b1, "R9"); run(OFF, 1'b0, "R9");
    end
    run(GAP, 1'b0, "R9");
    // R8 chopped lit state, carrier counted from reset release
    d_pwr = 1; d_pwm = 1;
    for (int i = 0; i < 2 * DIV; i++) step(((cyc + 1) % DIV) < DIV / 16, "R8");
    d_pwr = 0; run(20, 1'b0, "R8");
    @(negedge clk); #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule